// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable ratio N = P·B + A and emits one narrow pulse per completed division period, which is meant to feed a phase-frequency detector. P is the base modulus of a dual-modulus prescaler that divides by P or P+1. A swallow counter tracks how many prescaler periods have used the larger modulus. A main counter tracks the total number of prescaler periods.

The prescaler is a synchronous divide-by-4/5 core followed by a binary extension stage. The 2-bit mode input sets the extension, giving P = 4·2^mode, so P is 4, 8, 16 or 32. To make one prescaler period P+1 long, the core divides by 5 on the last core pass of that period. In each division period, the first A prescaler periods are P+1 input clocks long and the remaining B−A periods are P clocks long.

The ratio inputs are sampled only at period boundaries. A synchronous counter reset clears all counting state, so the first output period after release starts from a known phase. An invalid setting (B equal to zero, or B smaller than A) stops the divider and holds the output low.

Top module: `pdd_divider`

## Requirements
- R1: While a valid setting is held, div_out pulses exactly once every N = P·B + A input clocks, with P = 4·2^pre_mode (pre_mode 0,1,2,3 gives P = 4,8,16,32).
- R2: Within a period, each of the first A prescaler periods lasts P+1 clocks and each later prescaler period lasts P clocks; A = 0 gives N = P·B and A = B gives N = B·(P+1).
- R3: div_out is high for exactly one input clock per period.
- R4: While cnt_rst is high, div_out stays low and all counters stay cleared.
- R5: If cnt_rst is sampled low at edge 1 after being high, the first pulse is visible after edge N.
- R6: A setting with main_cnt = 0 or main_cnt < swallow_cnt holds div_out low. Once a valid setting is applied, the first pulse follows N+1 edges later: one edge loads the setting and N edges count.
- R7: A setting changed partway through a period does not affect that period. It takes effect from the period that starts at the next pulse.
- R8: After rst_n is released, and before any counting, div_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_rst | input | 1 | Synchronous counter reset, active high |
| swallow_cnt | input | A_W | Swallow count A |
| main_cnt | input | B_W | Main count B |
| pre_mode | input | MODE_W | Prescaler base modulus select, P = 4·2^pre_mode |
| div_out | output | 1 | One-clock pulse per completed period of N clocks |

## Verification
The hardest case to reach from the ports is a setting change that arrives partway through a period. The boundary that would load it has already passed, so the change shows only one period later, as a change in pulse spacing. The bench lets a pulse go by and writes a new setting a few clocks later. It then measures two consecutive intervals and expects the old N followed by the new N. The swallow edge cases (A = 0, A = B, and the smallest N of 4 and 5) are hit directly. Random settings in all four prescaler modes cover the rest.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
    // Smallest modulus of the synchronous core; the core adds one for a swallow pass.
    localparam int unsigned CORE_BASE = 4;
    localparam int unsigned CORE_W    = 3;

    typedef logic [CORE_W-1:0] core_cnt_t;

    // Base modulus P chosen by the mode select.
    function automatic int unsigned base_modulus(input int unsigned mode);
        return CORE_BASE << mode;
    endfunction
endpackage

// File: rtl/pdd_prescaler.sv
module pdd_prescaler #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              swallow,
    input  logic [MODE_W-1:0] mode,
    output logic              pre_tick
);
    import pdd_pkg::*;

    localparam int EXT_W = (1 << MODE_W) - 1;

    typedef struct packed {
        core_cnt_t        core;
        logic [EXT_W-1:0] ext;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [EXT_W-1:0] ext_limit;
    logic             ext_last;
    core_cnt_t        core_top;
    logic             core_wrap;

    always_comb begin
        ext_limit = EXT_W'((32'd1 << mode) - 32'd1);
        ext_last  = (st_q.ext == ext_limit);
        // the divide-by-5 pass is the last core pass of a swallowing period
        core_top  = (swallow && ext_last) ? core_cnt_t'(CORE_BASE) : core_cnt_t'(CORE_BASE - 1);
        core_wrap = (st_q.core == core_top);
        pre_tick  = core_wrap && ext_last && !hold;

        st_d = st_q;
        if (hold) begin
            st_d = '0;
        end else if (core_wrap) begin
            st_d.core = '0;
            st_d.ext  = ext_last ? '0 : st_q.ext + 1'b1;
        end else begin
            st_d.core = st_q.core + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pdd_swallow_ctrl.sv
module pdd_swallow_ctrl #(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           pre_tick,
    input  logic [A_W-1:0] a_cfg,
    input  logic [B_W-1:0] b_cfg,
    output logic           swallow,
    output logic           boundary
);
    typedef struct packed {
        logic [A_W-1:0] a_cnt;
        logic [B_W-1:0] b_cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        swallow  = (st_q.a_cnt < a_cfg);
        boundary = pre_tick && (st_q.b_cnt == b_cfg - 1'b1);

        st_d = st_q;
        if (hold || boundary) begin
            st_d = '0;
        end else if (pre_tick) begin
            st_d.b_cnt = st_q.b_cnt + 1'b1;
            if (swallow) st_d.a_cnt = st_q.a_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pdd_divider.sv
module pdd_divider #(
    parameter int A_W    = 6,
    parameter int B_W    = 13,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_rst,
    input  logic [A_W-1:0]    swallow_cnt,
    input  logic [B_W-1:0]    main_cnt,
    input  logic [MODE_W-1:0] pre_mode,
    output logic              div_out
);
    localparam int CMP_W = A_W + B_W;

    typedef struct packed {
        logic [A_W-1:0]    a;
        logic [B_W-1:0]    b;
        logic [MODE_W-1:0] mode;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic out;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              cfg_valid;
    logic              hold;
    logic              pre_tick;
    logic              swallow;
    logic              boundary;
    logic [A_W-1:0]    cfg_a;
    logic [B_W-1:0]    cfg_b;
    logic [MODE_W-1:0] cfg_mode;

    assign cfg_a    = st_q.cfg.a;
    assign cfg_b    = st_q.cfg.b;
    assign cfg_mode = st_q.cfg.mode;

    pdd_prescaler #(.MODE_W(MODE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .swallow  (swallow),
        .mode     (cfg_mode),
        .pre_tick (pre_tick)
    );

    pdd_swallow_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .pre_tick (pre_tick),
        .a_cfg    (cfg_a),
        .b_cfg    (cfg_b),
        .swallow  (swallow),
        .boundary (boundary)
    );

    always_comb begin
        cfg_valid = (cfg_b != '0) &&
                    (CMP_W'(cfg_a) <= CMP_W'(cfg_b));
        hold      = cnt_rst || !cfg_valid;

        st_d     = st_q;
        st_d.out = boundary;
        // settings are sampled only while idle or at a period boundary
        if (hold || boundary) begin
            st_d.cfg.a    = swallow_cnt;
            st_d.cfg.b    = main_cnt;
            st_d.cfg.mode = pre_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_out = st_q.out;
endmodule

// File: rtl/pdd_divider_chk.sv
module pdd_divider_chk #(
    parameter int A_W    = 6,
    parameter int B_W    = 13,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_rst,
    input logic              div_out,
    input logic              hold,
    input logic              cfg_valid,
    input logic              pre_tick,
    input logic              swallow,
    input logic              boundary,
    input logic [A_W-1:0]    cfg_a,
    input logic [B_W-1:0]    cfg_b,
    input logic [MODE_W-1:0] cfg_mode
);
    localparam int LEN_W = (1 << MODE_W) + 3;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_exp;

    assign len_exp = LEN_W'(32'd4 << cfg_mode) + LEN_W'(swallow);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                len_q <= LEN_W'(1);
        else if (hold || pre_tick) len_q <= LEN_W'(1);
        else                       len_q <= len_q + 1'b1;
    end

    // R2
    prescale_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |-> (len_q == len_exp));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R4
    cnt_rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> !div_out);

    // R6
    invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !div_out);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !boundary) |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(cfg_mode)));
endmodule

bind pdd_divider pdd_divider_chk #(.A_W(A_W), .B_W(B_W), .MODE_W(MODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_rst   (cnt_rst),
    .div_out   (div_out),
    .hold      (hold),
    .cfg_valid (cfg_valid),
    .pre_tick  (pre_tick),
    .swallow   (swallow),
    .boundary  (boundary),
    .cfg_a     (cfg_a),
    .cfg_b     (cfg_b),
    .cfg_mode  (cfg_mode)
);

// File: tb/tb_pdd_divider.sv
module tb_pdd_divider;
    localparam int A_W    = 6;
    localparam int B_W    = 13;
    localparam int MODE_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_rst = 1'b1;
    logic [A_W-1:0]    swallow_cnt = '0;
    logic [B_W-1:0]    main_cnt = '0;
    logic [MODE_W-1:0] pre_mode = '0;
    logic              div_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pdd_divider #(.A_W(A_W), .B_W(B_W), .MODE_W(MODE_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_rst     (cnt_rst),
        .swallow_cnt (swallow_cnt),
        .main_cnt    (main_cnt),
        .pre_mode    (pre_mode),
        .div_out     (div_out)
    );

    function automatic int exp_n(input int a, input int b, input int m);
        return (4 << m) * b + a;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int cycles, input int limit);
        cycles = 0;
        forever begin
            @(negedge clk);
            cycles++;
            if (div_out || cycles > limit) break;
        end
    endtask

    task automatic set_cfg(input int a, input int b, input int m);
        swallow_cnt = A_W'(a);
        main_cnt    = B_W'(b);
        pre_mode    = MODE_W'(m);
    endtask

    // Release from counter reset with the given setting; check first pulse and next interval.
    task automatic release_and_measure(input int a, input int b, input int m);
        int n, k, k2;
        n = exp_n(a, b, m);
        @(negedge clk);
        set_cfg(a, b, m);
        cnt_rst = 1'b1;
        repeat (2) @(negedge clk);
        cnt_rst = 1'b0;
        wait_pulse(k, 4 * n + 10);
        check(k == n, "R5 first pulse", k, n);
        @(negedge clk);
        check(!div_out, "R3 pulse width", int'(div_out), 0);
        wait_pulse(k2, 4 * n + 10);
        k2 = k2 + 1;
        check(k2 == n, "R1 period", k2, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k, k2, pulses;
        void'($urandom(32'd20240611));

        // R8: reset state
        repeat (3) @(negedge clk);
        check(!div_out, "R8 in reset", int'(div_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!div_out, "R8 after reset", int'(div_out), 0);

        // R4: counter reset held with a valid setting
        set_cfg(0, 1, 0);
        pulses = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (div_out) pulses++;
        end
        check(pulses == 0, "R4 held in counter reset", pulses, 0);

        // R2 corners: smallest ratios, no swallow, all swallow
        release_and_measure(0, 1, 0);
        release_and_measure(1, 1, 0);
        release_and_measure(0, 7, 2);
        release_and_measure(9, 9, 1);
        release_and_measure(5, 5, 3);

        // R4: counter reset mid-period, then release restarts the period
        @(negedge clk);
        set_cfg(2, 4, 1);
        cnt_rst = 1'b0;
        repeat (13) @(negedge clk);
        cnt_rst = 1'b1;
        pulses = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (div_out) pulses++;
        end
        check(pulses == 0, "R4 reset mid-period", pulses, 0);
        cnt_rst = 1'b0;
        wait_pulse(k, 400);
        check(k == exp_n(2, 4, 1), "R5 restart after mid-period reset", k, exp_n(2, 4, 1));

        // R6: B < A and B == 0 keep the output low
        @(negedge clk);
        cnt_rst = 1'b1;
        set_cfg(5, 3, 0);
        @(negedge clk);
        cnt_rst = 1'b0;
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_out) pulses++;
        end
        check(pulses == 0, "R6 B<A holds low", pulses, 0);
        set_cfg(0, 0, 2);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_out) pulses++;
        end
        check(pulses == 0, "R6 B=0 holds low", pulses, 0);
        set_cfg(2, 3, 0);
        wait_pulse(k, 200);
        check(k == exp_n(2, 3, 0) + 1, "R6 first pulse after valid", k, exp_n(2, 3, 0) + 1);

        // R7: setting changed mid-period applies one period later
        release_and_measure(1, 2, 0);
        repeat (3) @(negedge clk);
        set_cfg(3, 5, 1);
        wait_pulse(k, 400);
        k = k + 3;
        check(k == exp_n(1, 2, 0), "R7 old ratio kept", k, exp_n(1, 2, 0));
        wait_pulse(k2, 400);
        check(k2 == exp_n(3, 5, 1), "R7 new ratio applied", k2, exp_n(3, 5, 1));

        // R1/R2: random settings over every mode
        for (int it = 0; it < 24; it++) begin
            int m, b, a;
            m = int'($urandom_range(3, 0));
            b = int'($urandom_range(20, 1));
            a = int'($urandom_range(b, 0));
            release_and_measure(a, b, m);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule